// File: doc/BRIEF.md
# Adder-Subtractor with Registered Condition Flags

This block adds or subtracts two W-bit two's-complement operands through a single ripple chain of full-adder cells and reports the outcome through four status flags: negative, zero, carry and overflow. Subtraction reuses the adder: the second operand is inverted bit by bit and a carry-in of one is injected, so a set carry after a subtract means that no borrow occurred.

The flags are held in a register that loads only when the update enable is high. Seven comparison predicates are derived from the stored flags: equal, not-equal, unsigned higher, unsigned lower, signed less-than, signed greater-or-equal and signed greater-than. A compare is therefore done as one subtract with update enabled, after which the predicates describe that pair of operands until the next update. The result output is combinational and appears in the same cycle as the operands.

Top module: `arith_flag_unit`

## Requirements
- R1: With `op_sub`=0, `result` equals (`a` + `b`) modulo 2^W in the same cycle as the inputs.
- R2: With `op_sub`=1, `result` equals `a` + ~`b` + 1 modulo 2^W, that is `a` − `b`, in the same cycle as the inputs.
- R3: On an update, the stored negative flag takes bit W−1 of the result, and the stored zero flag is set exactly when every result bit is 0.
- R4: On an update, the stored carry flag takes the carry out of bit W−1. For an add, 1 means unsigned overflow. For a subtract, 1 means `a` ≥ `b` unsigned, and 0 means a borrow.
- R5: On an update, the stored overflow flag is the XOR of the carry into bit W−1 and the carry out of it, so it is set exactly when the signed result is out of range.
- R6: The flags load on a rising clock edge only while `upd_en` is 1. Otherwise all four keep their value.
- R7: A synchronous `rst` clears all four flags to 0, and a reset takes priority over `upd_en`.
- R8: `pred_eq` equals the stored zero flag, and `pred_ne` is its inverse.
- R9: `pred_hi` is carry=1 and zero=0. `pred_lo` is carry=0.
- R10: `pred_lt` is negative≠overflow, `pred_ge` is negative=overflow, and `pred_gt` is zero=0 and negative=overflow.
- R11: The predicates depend only on the stored flags. A change of `a`, `b` or `op_sub` before the next update leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the flags |
| op_sub | input | 1 | 0 selects add, 1 selects subtract |
| upd_en | input | 1 | Load the flag register at the next edge |
| a | input | W | First operand (minuend) |
| b | input | W | Second operand (subtrahend) |
| result | output | W | Combinational sum or difference |
| flag_n | output | 1 | Stored negative flag |
| flag_z | output | 1 | Stored zero flag |
| flag_c | output | 1 | Stored carry / no-borrow flag |
| flag_v | output | 1 | Stored signed overflow flag |
| pred_eq | output | 1 | Operands were equal |
| pred_ne | output | 1 | Operands differed |
| pred_hi | output | 1 | Unsigned a > b |
| pred_lo | output | 1 | Unsigned a < b |
| pred_lt | output | 1 | Signed a < b |
| pred_ge | output | 1 | Signed a ≥ b |
| pred_gt | output | 1 | Signed a > b |

## Verification
The assertions check on every cycle that the flags hold without an update and clear on reset, that the negative, zero and no-borrow flags follow the previous cycle's result and operands, that overflow follows the sign rule for additions, and that complementary predicates never agree. Only the bench scenarios can show the full arithmetic against a reference model at both 32 and 4 bits, including the 4-bit corners 7−(−1), (−8)−1 and 0−0. They also show that the predicates stay frozen while the operands move between updates.

// File: rtl/afu_pkg.sv
package afu_pkg;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } afu_op_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic carry;
        logic ovf;
    } afu_flags_t;

    typedef struct packed {
        logic eq;
        logic ne;
        logic hi;
        logic lo;
        logic lt;
        logic ge;
        logic gt;
    } afu_cond_t;

    localparam afu_flags_t AFU_FLAGS_CLEAR = '{neg: 1'b0, zero: 1'b0, carry: 1'b0, ovf: 1'b0};

    // Builds the condition predicates from a stored flag set.
    function automatic afu_cond_t afu_eval_cond(input afu_flags_t f);
        afu_cond_t c;
        c.eq = f.zero;
        c.ne = ~f.zero;
        c.hi = f.carry & ~f.zero;
        c.lo = ~f.carry;
        c.lt = f.neg ^ f.ovf;
        c.ge = ~(f.neg ^ f.ovf);
        c.gt = ~f.zero & ~(f.neg ^ f.ovf);
        return c;
    endfunction

    // The carry-in of the chain is 1 exactly for subtraction.
    function automatic logic afu_carry_in(input afu_op_e op);
        return (op == OP_SUB);
    endfunction

endpackage

// File: rtl/afu_full_adder.sv
module afu_full_adder (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    logic half_s;

    always_comb begin
        half_s = x ^ y;
        s      = half_s ^ ci;
        co     = (x & y) | (half_s & ci);
    end
endmodule

// File: rtl/afu_operand_prep.sv
module afu_operand_prep
    import afu_pkg::*;
#(
    parameter int W = 32
) (
    input  afu_op_e        op,
    input  logic [W-1:0]   b_in,
    output logic [W-1:0]   b_eff,
    output logic           cin
);
    logic invert;

    assign invert = (op == OP_SUB);
    assign cin    = afu_carry_in(op);

    // One XOR per bit conditionally complements the second operand.
    for (genvar i = 0; i < W; i++) begin : g_inv
        assign b_eff[i] = b_in[i] ^ invert;
    end
endmodule

// File: rtl/afu_ripple_chain.sv
module afu_ripple_chain #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         c_into_top,
    output logic         c_out_top
);
    logic [W:0] carry;

    assign carry[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_cell
        afu_full_adder u_fa (
            .x  (x[i]),
            .y  (y[i]),
            .ci (carry[i]),
            .s  (sum[i]),
            .co (carry[i+1])
        );
    end

    assign c_into_top = carry[W-1];
    assign c_out_top  = carry[W];
endmodule

// File: rtl/afu_flag_reg.sv
module afu_flag_reg
    import afu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  afu_flags_t d,
    output afu_flags_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= AFU_FLAGS_CLEAR;
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/afu_cond_unit.sv
module afu_cond_unit
    import afu_pkg::*;
(
    input  afu_flags_t flags,
    output afu_cond_t  cond
);
    always_comb begin
        cond = afu_eval_cond(flags);
    end
endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
    import afu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         op_sub,
    input  logic         upd_en,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] result,
    output logic         flag_n,
    output logic         flag_z,
    output logic         flag_c,
    output logic         flag_v,
    output logic         pred_eq,
    output logic         pred_ne,
    output logic         pred_hi,
    output logic         pred_lo,
    output logic         pred_lt,
    output logic         pred_ge,
    output logic         pred_gt
);
    localparam int MSB = W - 1;

    afu_op_e    op;
    logic [W-1:0] b_eff;
    logic       cin;
    logic [W-1:0] sum;
    logic       c_into_top;
    logic       c_out_top;
    afu_flags_t next_flags;
    afu_flags_t stored;
    afu_cond_t  cond;

    assign op = afu_op_e'(op_sub);

    afu_operand_prep #(.W(W)) u_prep (
        .op    (op),
        .b_in  (b),
        .b_eff (b_eff),
        .cin   (cin)
    );

    afu_ripple_chain #(.W(W)) u_chain (
        .x          (a),
        .y          (b_eff),
        .cin        (cin),
        .sum        (sum),
        .c_into_top (c_into_top),
        .c_out_top  (c_out_top)
    );

    always_comb begin
        next_flags.neg   = sum[MSB];
        next_flags.zero  = ~|sum;
        next_flags.carry = c_out_top;
        next_flags.ovf   = c_into_top ^ c_out_top;
    end

    afu_flag_reg u_flags (
        .clk  (clk),
        .rst  (rst),
        .load (upd_en),
        .d    (next_flags),
        .q    (stored)
    );

    afu_cond_unit u_cond (
        .flags (stored),
        .cond  (cond)
    );

    assign result  = sum;
    assign flag_n  = stored.neg;
    assign flag_z  = stored.zero;
    assign flag_c  = stored.carry;
    assign flag_v  = stored.ovf;
    assign pred_eq = cond.eq;
    assign pred_ne = cond.ne;
    assign pred_hi = cond.hi;
    assign pred_lo = cond.lo;
    assign pred_lt = cond.lt;
    assign pred_ge = cond.ge;
    assign pred_gt = cond.gt;
endmodule

// File: rtl/afu_checker.sv
module afu_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         op_sub,
    input logic         upd_en,
    input logic [W-1:0] a,
    input logic [W-1:0] b,
    input logic [W-1:0] result,
    input logic         flag_n,
    input logic         flag_z,
    input logic         flag_c,
    input logic         flag_v,
    input logic         pred_eq,
    input logic         pred_ne,
    input logic         pred_hi,
    input logic         pred_lo,
    input logic         pred_lt,
    input logic         pred_ge,
    input logic         pred_gt
);
    assert_reset_clears_R7: assert property (@(posedge clk)
        rst |=> ({flag_n, flag_z, flag_c, flag_v} == 4'b0000));

    assert_hold_no_update_R6: assert property (@(posedge clk) disable iff (rst)
        !upd_en |=> $stable({flag_n, flag_z, flag_c, flag_v}));

    assert_neg_zero_R3: assert property (@(posedge clk) disable iff (rst)
        upd_en |=> (flag_n == $past(result[W-1])) && (flag_z == ($past(result) == '0)));

    assert_no_borrow_R4: assert property (@(posedge clk) disable iff (rst)
        (upd_en && op_sub) |=> (flag_c == ($past(a) >= $past(b))));

    assert_add_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !op_sub && (a[W-1] == b[W-1])) |=>
            (flag_v == ($past(result[W-1]) != $past(a[W-1]))));

    assert_add_mixed_sign_R5: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !op_sub && (a[W-1] != b[W-1])) |=> !flag_v);

    assert_eq_ne_R8: assert property (@(posedge clk) disable iff (rst)
        pred_eq != pred_ne);

    assert_hi_lo_R9: assert property (@(posedge clk) disable iff (rst)
        pred_hi |-> !pred_lo);

    assert_lt_ge_R10: assert property (@(posedge clk) disable iff (rst)
        (pred_lt != pred_ge) && (!pred_gt || pred_ge));
endmodule

bind arith_flag_unit afu_checker #(.W(W)) u_afu_checker (
    .clk     (clk),
    .rst     (rst),
    .op_sub  (op_sub),
    .upd_en  (upd_en),
    .a       (a),
    .b       (b),
    .result  (result),
    .flag_n  (flag_n),
    .flag_z  (flag_z),
    .flag_c  (flag_c),
    .flag_v  (flag_v),
    .pred_eq (pred_eq),
    .pred_ne (pred_ne),
    .pred_hi (pred_hi),
    .pred_lo (pred_lo),
    .pred_lt (pred_lt),
    .pred_ge (pred_ge),
    .pred_gt (pred_gt)
);

// File: tb/test_arith_flag_unit.sv
module test_arith_flag_unit;
    localparam int WB = 32;
    localparam int WS = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic op_sub = 1'b0;
    logic upd_en = 1'b0;
    logic [WB-1:0] a_b = '0, b_b = '0;
    logic [WS-1:0] a_s = '0, b_s = '0;

    logic [WB-1:0] res_b;
    logic [WS-1:0] res_s;
    logic [3:0] fl_b, fl_s;   // {n,z,c,v}
    logic [6:0] pr_b, pr_s;   // {eq,ne,hi,lo,lt,ge,gt}

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    logic [3:0] mf_b = 4'b0000;
    logic [3:0] mf_s = 4'b0000;

    always #2 clk = ~clk;

    arith_flag_unit #(.W(WB)) i_arith_flag_unit (
        .clk(clk), .rst(rst), .op_sub(op_sub), .upd_en(upd_en), .a(a_b), .b(b_b),
        .result(res_b), .flag_n(fl_b[3]), .flag_z(fl_b[2]), .flag_c(fl_b[1]), .flag_v(fl_b[0]),
        .pred_eq(pr_b[6]), .pred_ne(pr_b[5]), .pred_hi(pr_b[4]), .pred_lo(pr_b[3]),
        .pred_lt(pr_b[2]), .pred_ge(pr_b[1]), .pred_gt(pr_b[0]));

    arith_flag_unit #(.W(WS)) i_arith_flag_unit_w4 (
        .clk(clk), .rst(rst), .op_sub(op_sub), .upd_en(upd_en), .a(a_s), .b(b_s),
        .result(res_s), .flag_n(fl_s[3]), .flag_z(fl_s[2]), .flag_c(fl_s[1]), .flag_v(fl_s[0]),
        .pred_eq(pr_s[6]), .pred_ne(pr_s[5]), .pred_hi(pr_s[4]), .pred_lo(pr_s[3]),
        .pred_lt(pr_s[2]), .pred_ge(pr_s[1]), .pred_gt(pr_s[0]));

    // Behavioural reference: integer arithmetic, signed range test for overflow.
    task automatic model(input int w, input longint unsigned x, input longint unsigned y,
                         input bit sub, output longint unsigned res, output logic [3:0] f);
        longint unsigned mask, xm, ym, yy, s;
        longint sx, sy, tr, hi_lim, lo_lim;
        mask = (64'd1 << w) - 64'd1;
        xm = x & mask;
        ym = y & mask;
        yy = sub ? (~ym & mask) : ym;
        s = xm + yy + (sub ? 64'd1 : 64'd0);
        res = s & mask;
        sx = xm[w-1] ? longint'(xm) - longint'(64'd1 << w) : longint'(xm);
        sy = ym[w-1] ? longint'(ym) - longint'(64'd1 << w) : longint'(ym);
        tr = sub ? sx - sy : sx + sy;
        hi_lim = longint'(64'd1 << (w - 1)) - 1;
        lo_lim = -longint'(64'd1 << (w - 1));
        f[3] = res[w-1];
        f[2] = (res == 0);
        f[1] = s[w];
        f[0] = (tr > hi_lim) || (tr < lo_lim);
    endtask

    function automatic logic [6:0] preds(input logic [3:0] f);
        logic n, z, c, v;
        {n, z, c, v} = f;
        return {z, !z, c && !z, !c, n != v, n == v, !z && (n == v)};
    endfunction

    task automatic check(input string what, input longint unsigned act, input longint unsigned exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic step(input logic [31:0] x, input logic [31:0] y, input bit sub,
                        input bit en, input string tag);
        longint unsigned rb, rs;
        logic [3:0] fb, fs;
        @(negedge clk);
        a_b = x; b_b = y; a_s = x[3:0]; b_s = y[3:0];
        op_sub = sub; upd_en = en;
        #1;
        model(WB, longint'(x), longint'(y), sub, rb, fb);
        model(WS, longint'(x), longint'(y), sub, rs, fs);
        check({tag, " R1 R2 result w32"}, res_b, rb);
        check({tag, " R1 R2 result w4"}, res_s, rs);
        check({tag, " R11 preds before edge w32"}, pr_b, preds(mf_b));
        check({tag, " R11 preds before edge w4"}, pr_s, preds(mf_s));
        @(posedge clk);
        if (en) begin
            mf_b = fb;
            mf_s = fs;
        end
        #1;
        check({tag, " flags w32"}, fl_b, mf_b);
        check({tag, " flags w4"}, fl_s, mf_s);
        check({tag, " preds w32"}, pr_b, preds(mf_b));
        check({tag, " preds w4"}, pr_s, preds(mf_s));
        upd_en = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R7 reset flags w32", fl_b, 4'b0000);
        check("R7 reset flags w4", fl_s, 4'b0000);
        check("R7 R9 reset preds w32", pr_b, preds(4'b0000));
        @(negedge clk);
        rst = 1'b0;

        step(32'd5, 32'd3, 1'b0, 1'b1, "R1 add small");
        step(32'd10, 32'd5, 1'b1, 1'b1, "R4 sub no borrow");
        step(32'd10, 32'd13, 1'b1, 1'b1, "R4 sub borrow R9 lower");
        step(32'd7, 32'hFFFF_FFFF, 1'b1, 1'b1, "R5 seven minus minus-one");
        step(32'hFFFF_FFF8, 32'd1, 1'b1, 1'b1, "R5 min minus one");
        step(32'd0, 32'd0, 1'b1, 1'b1, "R8 zero minus zero");
        step(32'hFFFF_FFFF, 32'd1, 1'b0, 1'b1, "R4 add carry out");
        step(32'h7FFF_FFFF, 32'd1, 1'b0, 1'b1, "R5 add positive overflow");
        step(32'h8000_0001, 32'hFFFF_FFFA, 1'b0, 1'b1, "R5 add negative overflow");
        step(32'd3, 32'd7, 1'b1, 1'b1, "R3 negative result R10 less");
        step(32'hFFFF_FFFD, 32'hFFFF_FFFC, 1'b1, 1'b1, "R10 greater signed");
        step(32'd5, 32'hFFFF_FFFD, 1'b1, 1'b1, "R10 five minus minus-three");
        step(32'd9, 32'd2, 1'b1, 1'b1, "R9 unsigned higher");
        step(32'd123, 32'd456, 1'b1, 1'b0, "R6 hold without update");
        step(32'd0, 32'd0, 1'b0, 1'b0, "R6 R11 operands move no update");
        for (int i = 0; i < 60; i++) begin
            step($urandom, $urandom, 1'($urandom), 1'($urandom), "R2 R3 random");
        end

        @(negedge clk);
        rst = 1'b1; upd_en = 1'b1; a_b = 32'd1; b_b = 32'd2; a_s = 4'd1; b_s = 4'd2; op_sub = 1'b1;
        @(posedge clk);
        #1;
        mf_b = 4'b0000; mf_s = 4'b0000;
        check("R7 reset wins over update w32", fl_b, 4'b0000);
        check("R7 reset wins over update w4", fl_s, 4'b0000);
        @(negedge clk);
        rst = 1'b0; upd_en = 1'b0;
        step(32'd4, 32'd4, 1'b1, 1'b1, "R8 equal after reset");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule